// File: doc/BRIEF.md
# Address-Latched Cartridge Bank Mapper

This block switches program and character-memory banks for a multi-game cartridge on an 8-bit console. A CPU write anywhere in the upper 32KB of the CPU address space loads a 12-bit control register. The value comes from the low twelve address lines of that write, and the data bus plays no part. The register is split into two 6-bit latch slices.

The register fields control the outputs as follows:
- A five-bit field picks a 32KB program bank and drives ROM address lines A15 to A19.
- One bit picks which of two ROM devices responds.
- One bit picks a 16KB or 32KB program window. In 16KB mode, a half-select bit picks the upper or lower 16KB half, and that half appears at both CPU $8000 and $C000.
- One bit picks horizontal or vertical nametable mirroring. This drives the console's nametable A10 line from the PPU address.
- One bit write-protects the 8KB character RAM by holding its active-low write enable high.

All outputs other than the register are combinational from the register and the live bus address. Values written in a cycle therefore take effect from the clock edge that captures them.

Top module: `addr_bank_mapper`

## Requirements
- R1: A write cycle has `cpu_stb`=1, `cpu_rw`=0 and `cpu_addr[15]`=1. On the clock edge of a write cycle, the register loads `cpu_addr[11:0]`, and the outputs reflect the new value after that edge.
- R2: `prg_addr_hi[5:1]` (ROM A19..A15) equal register bits 7..3, with bit 7 at the most significant position.
- R3: `rom_sel` equals register bit 8. 0 selects the first ROM device and 1 selects the second.
- R4: When register bit 0 is 0 (32KB mode), `prg_addr_hi[0]` (ROM A14) follows `cpu_addr[14]`.
- R5: When register bit 0 is 1 (16KB mode), `prg_addr_hi[0]` equals register bit 1, whatever the value of `cpu_addr[14]`.
- R6: When register bit 9 is 1 (horizontal mirroring), `ciram_a10` equals `ppu_addr[11]`. When it is 0 (vertical mirroring), `ciram_a10` equals `ppu_addr[10]`.
- R7: When register bit 2 is 1, `chr_we_n` is held at 1. When it is 0, `chr_we_n` follows `ppu_we_n`.
- R8: While `rst_n` is 0, the register clears to zero. This gives bank 0 of the first ROM, 32KB mode, vertical mirroring and writable character RAM.
- R9: The register does not change in these cases: a read cycle (`cpu_rw`=1), a write with `cpu_addr[15]`=0, or a cycle with `cpu_stb`=0.
- R10: When writes occur on consecutive clock edges, the last one decides the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | CPU direction, 1 = read, 0 = write |
| cpu_stb | input | 1 | Qualifies a valid CPU bus cycle in this clock |
| ppu_addr | input | 14 | PPU address bus |
| ppu_we_n | input | 1 | PPU character-memory write enable, active low |
| prg_addr_hi | output | 6 | Program ROM address lines A19..A14 |
| rom_sel | output | 1 | ROM device select, 0 = first, 1 = second |
| ciram_a10 | output | 1 | Nametable RAM address line 10 |
| chr_we_n | output | 1 | Gated character RAM write enable, active low |

## Verification
The bench applies a set of register images and then sweeps `cpu_addr[14]` and the PPU address and write lines for each one. The sweep exposes three faults:
- A design that confuses the 16KB and 32KB behaviour shows ROM A14 tracking the CPU when it should be pinned.
- A design that decodes mirroring backwards selects the wrong PPU address bit.
- A design that inverts the write-protect gate lets character RAM writes through.

Directed cases cover several writes that must not load the register: reads at $FFFF, writes at $7FFF, and unqualified strobes. These cases catch a decoder that loads on the wrong condition. A write at $8E55 sets register bits 10 and 11 and must leave every output unaffected by them. Back-to-back writes catch a latch that drops or delays the second value. A reset applied after setting every bit must return all outputs to the cleared state.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
   typedef enum logic {
      MIR_VERT = 1'b0,
      MIR_HORZ = 1'b1
   } mirror_t;

   typedef enum logic {
      PRG_32K = 1'b0,
      PRG_16K = 1'b1
   } prg_mode_t;
endpackage

// File: rtl/aml_addr_latch.sv
module aml_addr_latch #(
   parameter int LATCH_W = 12,
   parameter int SLICE_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cap_en,
   input  logic [LATCH_W-1:0] addr_in,
   output logic [LATCH_W-1:0] q
);
   localparam int NUM_SLICES = LATCH_W / SLICE_W;

   generate
      if (LATCH_W % SLICE_W != 0) begin : g_bad_slice
         $error("LATCH_W must be a multiple of SLICE_W");
      end
   endgenerate

   genvar s;
   generate
      for (s = 0; s < NUM_SLICES; s++) begin : g_slice
         logic [SLICE_W-1:0] slice_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               slice_q <= '0;
            else if (cap_en)
               slice_q <= addr_in[s*SLICE_W +: SLICE_W];
         end
         assign q[s*SLICE_W +: SLICE_W] = slice_q;
      end
   endgenerate

   AST_CAPTURE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> q == $past(addr_in)); // R1
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> $stable(q)); // R9
endmodule

// File: rtl/aml_prg_window.sv
module aml_prg_window
   import mapper_pkg::*;
#(
   parameter int BANK_W     = 5,
   parameter bit ENABLE_16K = 1'b1
) (
   input  logic [BANK_W-1:0] bank,
   input  prg_mode_t         mode,
   input  logic              half,
   input  logic              cpu_a14,
   output logic [BANK_W:0]   prg_hi
);
   logic a14_out;

   generate
      if (ENABLE_16K) begin : g_dual_mode
         always_comb begin
            unique case (mode)
               PRG_16K: a14_out = half;
               default: a14_out = cpu_a14;
            endcase
         end
      end else begin : g_fixed_32k
         logic unused_ctl;
         assign unused_ctl = ^{mode, half};
         assign a14_out = cpu_a14;
      end
   endgenerate

   assign prg_hi = {bank, a14_out};
endmodule

// File: rtl/aml_nt_mirror.sv
module aml_nt_mirror
   import mapper_pkg::*;
(
   input  mirror_t mirror,
   input  logic    ppu_a10,
   input  logic    ppu_a11,
   output logic    ciram_a10
);
   always_comb begin
      unique case (mirror)
         MIR_HORZ: ciram_a10 = ppu_a11;
         default:  ciram_a10 = ppu_a10;
      endcase
   end
endmodule

// File: rtl/aml_chr_gate.sv
module aml_chr_gate (
   input  logic protect,
   input  logic we_n_in,
   output logic we_n_out
);
   assign we_n_out = we_n_in | protect;
endmodule

// File: rtl/addr_bank_mapper.sv
module addr_bank_mapper
   import mapper_pkg::*;
#(
   parameter int CPU_AW     = 16,
   parameter int PPU_AW     = 14,
   parameter int LATCH_W    = 12,
   parameter int SLICE_W    = 6,
   parameter int BANK_W     = 5,
   parameter int BANK_LSB   = 3,
   parameter int MODE_BIT   = 0,
   parameter int HALF_BIT   = 1,
   parameter int WP_BIT     = 2,
   parameter int ROMSEL_BIT = 8,
   parameter int MIRROR_BIT = 9,
   parameter bit ENABLE_16K = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic              cpu_rw,
   input  logic              cpu_stb,
   input  logic [PPU_AW-1:0] ppu_addr,
   input  logic              ppu_we_n,
   output logic [BANK_W:0]   prg_addr_hi,
   output logic              rom_sel,
   output logic              ciram_a10,
   output logic              chr_we_n
);
   localparam int BANK_MSB = BANK_LSB + BANK_W - 1;
   localparam int WIN_BIT  = CPU_AW - 1;
   localparam int A14_BIT  = CPU_AW - 2;

   generate
      if (BANK_MSB >= LATCH_W || MIRROR_BIT >= LATCH_W || ROMSEL_BIT >= LATCH_W)
      begin : g_bad_field
         $error("field positions exceed latch width");
      end
      if (LATCH_W > A14_BIT) begin : g_bad_width
         $error("latch overlaps decoded address lines");
      end
      if (PPU_AW < 12) begin : g_bad_ppu
         $error("PPU address too narrow for mirroring");
      end
   endgenerate

   logic               wr_cycle;
   logic [LATCH_W-1:0] ctl;
   prg_mode_t          mode;
   mirror_t            mirror;

   assign wr_cycle = cpu_stb && !cpu_rw && cpu_addr[WIN_BIT];

   aml_addr_latch #(.LATCH_W(LATCH_W), .SLICE_W(SLICE_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (wr_cycle),
      .addr_in (cpu_addr[LATCH_W-1:0]),
      .q       (ctl)
   );

   assign mode   = prg_mode_t'(ctl[MODE_BIT]);
   assign mirror = mirror_t'(ctl[MIRROR_BIT]);

   aml_prg_window #(.BANK_W(BANK_W), .ENABLE_16K(ENABLE_16K)) u_prg (
      .bank    (ctl[BANK_MSB:BANK_LSB]),
      .mode    (mode),
      .half    (ctl[HALF_BIT]),
      .cpu_a14 (cpu_addr[A14_BIT]),
      .prg_hi  (prg_addr_hi)
   );

   assign rom_sel = ctl[ROMSEL_BIT];

   aml_nt_mirror u_mir (
      .mirror    (mirror),
      .ppu_a10   (ppu_addr[10]),
      .ppu_a11   (ppu_addr[11]),
      .ciram_a10 (ciram_a10)
   );

   aml_chr_gate u_chr (
      .protect  (ctl[WP_BIT]),
      .we_n_in  (ppu_we_n),
      .we_n_out (chr_we_n)
   );

   logic unused_lines;
   assign unused_lines = ^{cpu_addr, ppu_addr, ctl};

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (prg_addr_hi[BANK_W:1] == '0 && !rom_sel)); // R8
   AST_A14_32K: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PRG_32K) |-> prg_addr_hi[0] == cpu_addr[A14_BIT]); // R4
   AST_A14_16K_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
      (ENABLE_16K && mode == PRG_16K && $stable(ctl)) |-> $stable(prg_addr_hi)); // R5
   AST_CHR_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
      ctl[WP_BIT] |-> chr_we_n); // R7
   AST_MIRROR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      ciram_a10 == (mirror == MIR_HORZ ? ppu_addr[11] : ppu_addr[10])); // R6
endmodule

// File: tb/sim_addr_bank_mapper.sv
`timescale 1ns/1ps
module sim_addr_bank_mapper;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic        cpu_rw = 1'b1;
   logic        cpu_stb = 1'b0;
   logic [13:0] ppu_addr = '0;
   logic        ppu_we_n = 1'b1;
   logic [5:0]  prg_addr_hi;
   logic        rom_sel;
   logic        ciram_a10;
   logic        chr_we_n;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   addr_bank_mapper u0 (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
      .cpu_stb(cpu_stb), .ppu_addr(ppu_addr), .ppu_we_n(ppu_we_n),
      .prg_addr_hi(prg_addr_hi), .rom_sel(rom_sel), .ciram_a10(ciram_a10),
      .chr_we_n(chr_we_n)
   );

   localparam int NVEC = 8;
   localparam logic [15:0] VEC [NVEC] = '{
      16'h8000, 16'hFFFF, 16'h80F8, 16'h8101,
      16'h8203, 16'hC004, 16'hA0A8, 16'h8E55
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_cycle(input logic [15:0] a, input logic rw, input logic stb);
      @(negedge clk);
      cpu_addr = a; cpu_rw = rw; cpu_stb = stb;
      @(negedge clk);
      cpu_stb = 1'b0; cpu_rw = 1'b1;
   endtask

   // Checks all outputs against the register image reg_v, sweeping probe lines.
   task automatic check_image(input logic [11:0] reg_v);
      for (int a14 = 0; a14 < 2; a14++) begin
         cpu_addr = {1'b0, a14[0], 14'h0};
         #1;
         check("R2", prg_addr_hi[5:1], reg_v[7:3]);
         check("R3", rom_sel, reg_v[8]);
         if (reg_v[0])
            check("R5", prg_addr_hi[0], reg_v[1]);
         else
            check("R4", prg_addr_hi[0], a14);
      end
      for (int p = 0; p < 4; p++) begin
         ppu_addr = {2'b00, p[1], p[0], 10'h0};
         #1;
         check("R6", ciram_a10, reg_v[9] ? p[1] : p[0]);
      end
      for (int w = 0; w < 2; w++) begin
         ppu_we_n = w[0];
         #1;
         check("R7", chr_we_n, reg_v[2] ? 1 : w);
      end
      ppu_we_n = 1'b1;
   endtask

   initial begin
      #(4 * 200000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8: reset state
      check_image(12'h000);

      // R1: table of write images, walked by one loop
      for (int i = 0; i < NVEC; i++) begin
         bus_cycle(VEC[i], 1'b0, 1'b1);
         check_image(VEC[i][11:0]);
      end

      // R9: non-loading cycles leave last image (0x8E55 -> 0xE55)
      bus_cycle(16'hFFFF, 1'b1, 1'b1);
      check_image(12'hE55);
      bus_cycle(16'h7FFF, 1'b0, 1'b1);
      check_image(12'hE55);
      bus_cycle(16'hFFFF, 1'b0, 1'b0);
      check_image(12'hE55);

      // R10: back-to-back writes, last wins
      @(negedge clk);
      cpu_addr = 16'h80F8; cpu_rw = 1'b0; cpu_stb = 1'b1;
      @(negedge clk);
      cpu_addr = 16'h8203;
      @(negedge clk);
      cpu_stb = 1'b0; cpu_rw = 1'b1;
      check_image(12'h203);

      // R8: reset after all bits set
      bus_cycle(16'hFFFF, 1'b0, 1'b1);
      check_image(12'hFFF);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check_image(12'h000);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule